// File: doc/BRIEF.md
# Floating-Point Round-and-Pack Stage

This block closes a double/single floating-point datapath. It receives an unpacked result: a sign, a biased exponent held as a 13-bit two's-complement value, and a 64-bit fraction whose leading one sits at bit 63. It applies the selected rounding mode at the precision's least significant bit and renormalises on carry-out. It then sorts the rounded value into one of four result classes and packs it into the 64-bit double-width register layout. Single-precision values use the same layout, with their exponent rebased to the double bias.

The four result classes are ZERO (zero fraction in), NORMAL (exponent inside the precision's window), OVER (exponent above the window) and UNDER (exponent at or below the window). Each result is classified directly from its inputs; no class depends on the previous one. Denormals are never produced, and UNDER always yields +0. Three exception flags leave the block every cycle and serve as sticky-summary set pulses for a control register. A trap-request output combines those flags with the instruction's trap qualifiers and the control register's disable bits.

The logic is combinational. The parameter `OUT_REG` (default 1) adds one register stage on all outputs.

Top module: `rp_round_pack`

## Requirements
- R1: A zero fraction input gives `{sign, 63'b0}` with inx, ovf, unf and trap all low.
- R2: Rounding mode encoding is 00 chop, 01 toward minus infinity, 10 nearest, 11 toward plus infinity. The round field is fraction bits 10..0 (double) or 39..0 (single). Nearest adds the field's top bit. A directed mode whose direction matches the sign adds an all-ones field. Otherwise nothing is added.
- R3: With `dyn_i`=1 the mode is taken from `ctl_rmode_i`, and `rmode_i` is ignored.
- R4: If rounding carries out of bit 63, the fraction becomes bit 63 alone and the exponent rises by one.
- R5: inx is high whenever the round field was nonzero before rounding, in every mode. It is also high on every OVER and UNDER result.
- R6: OVER occurs when the exponent is above 2046 (double) or 1150 (single). It raises ovf and inx. The result is signed infinity `{s,11'h7FF,52'b0}` if the rounding increment was nonzero; otherwise it is the signed largest finite value `{s,11'h7FE,52'hF..F}`.
- R7: UNDER occurs when the exponent is at or below 0 (double) or 896 (single). It returns all zeros and raises unf and inx.
- R8: A NORMAL result packs as sign at bit 63, exponent bits 10..0 at 62..52, and rounded fraction bits 62..11 at 51..0. Under nearest, an exact-half round field clears the precision's LSB: result bit 0 for double, bit 29 for single. Single results always carry zeros in bits 28..0.
- R9: trap is raised when any of these holds:
  - ovf, unless `q_sw_i` and `dis_ovf_i` are both set;
  - unf with `q_unf_en_i`, unless `q_sw_i`, `dis_unf_i` and `unf_zero_i` are all set;
  - inx with `q_inx_en_i`, unless `q_sw_i` and `dis_inx_i` are both set.
- R10: With `OUT_REG`=1, outputs follow the inputs one clock later, and asynchronous reset (`rst_n` low) clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Result sign |
| exp_i | input | 13 | Biased exponent, two's complement |
| frac_i | input | 64 | Normalised fraction, leading one at bit 63 |
| dbl_i | input | 1 | 1 = double precision, 0 = single |
| rmode_i | input | 2 | Instruction rounding mode |
| dyn_i | input | 1 | Take the mode from ctl_rmode_i |
| ctl_rmode_i | input | 2 | Control-register rounding mode |
| q_sw_i | input | 1 | Software-completion qualifier |
| q_unf_en_i | input | 1 | Underflow trap enable qualifier |
| q_inx_en_i | input | 1 | Inexact trap enable qualifier |
| dis_ovf_i | input | 1 | Control-register overflow disable |
| dis_unf_i | input | 1 | Control-register underflow disable |
| dis_inx_i | input | 1 | Control-register inexact disable |
| unf_zero_i | input | 1 | Control-register underflow-to-zero enable |
| res_o | output | 64 | Packed result |
| inx_o | output | 1 | Inexact flag |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| trap_o | output | 1 | Trap request |

## Verification
The assertions take for granted that a nonzero fraction arrives with bit 63 set. They also assume the exponent stays well inside the 13-bit signed range, so the carry increment cannot wrap. The stimulus builds every nonzero fraction with bit 63 forced high. Exponents come from bounded windows around each precision's overflow and underflow limits, never near ±4095. Zero fractions are only applied deliberately.

// File: rtl/rp_pkg.sv
package rp_pkg;
    localparam int FW      = 64;
    localparam int EW      = 13;
    localparam int XW      = 11;
    localparam int MW      = FW - XW - 1;
    localparam int RB_D    = 11;
    localparam int RB_S    = 40;
    localparam int BIAS_D  = 1023;
    localparam int BIAS_S  = 127;
    localparam int EMAX_D  = (1 << XW) - 2;
    localparam int EMIN_D  = 0;
    localparam int EMAX_S  = BIAS_D - BIAS_S + 254;
    localparam int EMIN_S  = BIAS_D - BIAS_S;

    typedef enum logic [1:0] {
        RM_CHOP = 2'b00,
        RM_DOWN = 2'b01,
        RM_NEAR = 2'b10,
        RM_UP   = 2'b11
    } rmode_t;

    typedef enum logic [1:0] {
        RC_ZERO,
        RC_NORMAL,
        RC_OVER,
        RC_UNDER
    } rclass_t;

    typedef struct packed {
        logic inx;
        logic ovf;
        logic unf;
    } flags_t;
endpackage

// File: rtl/rp_rounder.sv
module rp_rounder
    import rp_pkg::*;
#(
    parameter int W    = FW,
    parameter int E    = EW,
    parameter int RBD  = RB_D,
    parameter int RBS  = RB_S
) (
    input  logic         sign_i,
    input  logic [E-1:0] exp_i,
    input  logic [W-1:0] frac_i,
    input  logic         dbl_i,
    input  rmode_t       mode_i,
    output logic [W-1:0] frac_o,
    output logic [E-1:0] exp_o,
    output logic         lost_o,
    output logic         bump_o
);
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] FIELD_D = (ONE << RBD) - ONE;
    localparam logic [W-1:0] FIELD_S = (ONE << RBS) - ONE;
    localparam logic [W-1:0] HALF_D  = ONE << (RBD - 1);
    localparam logic [W-1:0] HALF_S  = ONE << (RBS - 1);
    localparam logic [W-1:0] LSB_D   = ONE << RBD;
    localparam logic [W-1:0] LSB_S   = ONE << RBS;

    logic [W-1:0] field, half, lsb, inc, shifted;
    logic [W:0]   sum;
    logic         carry, tie;

    always_comb begin
        field = dbl_i ? FIELD_D : FIELD_S;
        half  = dbl_i ? HALF_D  : HALF_S;
        lsb   = dbl_i ? LSB_D   : LSB_S;
        unique case (mode_i)
            RM_CHOP: inc = '0;
            RM_NEAR: inc = half;
            RM_UP:   inc = sign_i ? '0 : field;
            RM_DOWN: inc = sign_i ? field : '0;
            default: inc = '0;
        endcase
        sum     = {1'b0, frac_i} + {1'b0, inc};
        carry   = sum[W];
        shifted = carry ? {1'b1, sum[W-1:1]} : sum[W-1:0];
        tie     = (mode_i == RM_NEAR) && ((frac_i & field) == half);
        frac_o  = shifted & ~field & ~(tie ? lsb : '0);
        exp_o   = exp_i + {{(E-1){1'b0}}, carry};
        lost_o  = |(frac_i & field);
        bump_o  = |inc;
    end
endmodule

// File: rtl/rp_classify.sv
module rp_classify
    import rp_pkg::*;
#(
    parameter int E = EW
) (
    input  logic [E-1:0] exp_i,
    input  logic         zero_i,
    input  logic         dbl_i,
    output rclass_t      cls_o
);
    logic signed [E+1:0] ex, hi, lo;

    always_comb begin
        ex = E'(signed'(exp_i));
        ex = {{2{exp_i[E-1]}}, exp_i};
        hi = dbl_i ? (E+2)'(EMAX_D) : (E+2)'(EMAX_S);
        lo = dbl_i ? (E+2)'(EMIN_D) : (E+2)'(EMIN_S);
        if (zero_i)        cls_o = RC_ZERO;
        else if (ex > hi)  cls_o = RC_OVER;
        else if (ex <= lo) cls_o = RC_UNDER;
        else               cls_o = RC_NORMAL;
    end
endmodule

// File: rtl/rp_trap_gate.sv
module rp_trap_gate
    import rp_pkg::*;
(
    input  flags_t flags_i,
    input  logic   q_sw_i,
    input  logic   q_unf_en_i,
    input  logic   q_inx_en_i,
    input  logic   dis_ovf_i,
    input  logic   dis_unf_i,
    input  logic   dis_inx_i,
    input  logic   unf_zero_i,
    output logic   trap_o
);
    logic t_ovf, t_unf, t_inx;

    always_comb begin
        t_ovf  = flags_i.ovf && !(q_sw_i && dis_ovf_i);
        t_unf  = flags_i.unf && q_unf_en_i && !(q_sw_i && dis_unf_i && unf_zero_i);
        t_inx  = flags_i.inx && q_inx_en_i && !(q_sw_i && dis_inx_i);
        trap_o = t_ovf || t_unf || t_inx;
    end
endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
    import rp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sign_i,
    input  logic [EW-1:0] exp_i,
    input  logic [FW-1:0] frac_i,
    input  logic          dbl_i,
    input  logic [1:0]    rmode_i,
    input  logic          dyn_i,
    input  logic [1:0]    ctl_rmode_i,
    input  logic          q_sw_i,
    input  logic          q_unf_en_i,
    input  logic          q_inx_en_i,
    input  logic          dis_ovf_i,
    input  logic          dis_unf_i,
    input  logic          dis_inx_i,
    input  logic          unf_zero_i,
    output logic [FW-1:0] res_o,
    output logic          inx_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          trap_o
);
    rmode_t        mode;
    rclass_t       cls;
    flags_t        flg_c;
    logic [FW-1:0] frac_r, res_c;
    logic [EW-1:0] exp_r;
    logic          lost, bump, trap_c;

    assign mode = dyn_i ? rmode_t'(ctl_rmode_i) : rmode_t'(rmode_i);

    rp_rounder u_rnd (
        .sign_i (sign_i),
        .exp_i  (exp_i),
        .frac_i (frac_i),
        .dbl_i  (dbl_i),
        .mode_i (mode),
        .frac_o (frac_r),
        .exp_o  (exp_r),
        .lost_o (lost),
        .bump_o (bump)
    );

    rp_classify u_cls (
        .exp_i  (exp_r),
        .zero_i (frac_i == '0),
        .dbl_i  (dbl_i),
        .cls_o  (cls)
    );

    always_comb begin
        unique case (cls)
            RC_ZERO: begin
                res_c = {sign_i, {(FW-1){1'b0}}};
                flg_c = '{inx: 1'b0, ovf: 1'b0, unf: 1'b0};
            end
            RC_UNDER: begin
                res_c = '0;
                flg_c = '{inx: 1'b1, ovf: 1'b0, unf: 1'b1};
            end
            RC_OVER: begin
                res_c = bump ? {sign_i, {XW{1'b1}}, {MW{1'b0}}}
                             : {sign_i, {(XW-1){1'b1}}, 1'b0, {MW{1'b1}}};
                flg_c = '{inx: 1'b1, ovf: 1'b1, unf: 1'b0};
            end
            RC_NORMAL: begin
                res_c = {sign_i, exp_r[XW-1:0], frac_r[FW-2 -: MW]};
                flg_c = '{inx: lost, ovf: 1'b0, unf: 1'b0};
            end
            default: begin
                res_c = '0;
                flg_c = '0;
            end
        endcase
    end

    rp_trap_gate u_trap (
        .flags_i    (flg_c),
        .q_sw_i     (q_sw_i),
        .q_unf_en_i (q_unf_en_i),
        .q_inx_en_i (q_inx_en_i),
        .dis_ovf_i  (dis_ovf_i),
        .dis_unf_i  (dis_unf_i),
        .dis_inx_i  (dis_inx_i),
        .unf_zero_i (unf_zero_i),
        .trap_o     (trap_c)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_o  <= '0;
                    inx_o  <= 1'b0;
                    ovf_o  <= 1'b0;
                    unf_o  <= 1'b0;
                    trap_o <= 1'b0;
                end else begin
                    res_o  <= res_c;
                    inx_o  <= flg_c.inx;
                    ovf_o  <= flg_c.ovf;
                    unf_o  <= flg_c.unf;
                    trap_o <= trap_c;
                end
            end
        end else begin : g_comb
            assign res_o  = res_c;
            assign inx_o  = flg_c.inx;
            assign ovf_o  = flg_c.ovf;
            assign unf_o  = flg_c.unf;
            assign trap_o = trap_c;
        end
    endgenerate

    AST_IN_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_i != '0) |-> frac_i[FW-1]); // R4
    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_i == '0) |-> !(flg_c.inx || flg_c.ovf || flg_c.unf || trap_c)); // R1
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == RC_NORMAL) |-> frac_r[FW-1]); // R4
    AST_GUARD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == RC_NORMAL) |-> (frac_r[RB_D-1:0] == '0)); // R8
    AST_SGL_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl_i && cls == RC_NORMAL) |-> (res_c[RB_S-RB_D-1:0] == '0)); // R8
    AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
        flg_c.ovf |-> (flg_c.inx && res_c[FW-2 -: XW-1] == {(XW-1){1'b1}})); // R6
    AST_UNF_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flg_c.unf |-> (flg_c.inx && res_c == '0)); // R7
    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_c |-> (flg_c.inx || flg_c.ovf || flg_c.unf)); // R9
endmodule

// File: tb/sim_rp_round_pack.sv
module sim_rp_round_pack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sign_i = 1'b0;
    logic [12:0] exp_i = '0;
    logic [63:0] frac_i = '0;
    logic        dbl_i = 1'b0;
    logic [1:0]  rmode_i = '0;
    logic        dyn_i = 1'b0;
    logic [1:0]  ctl_rmode_i = '0;
    logic        q_sw_i = 1'b0, q_unf_en_i = 1'b0, q_inx_en_i = 1'b0;
    logic        dis_ovf_i = 1'b0, dis_unf_i = 1'b0, dis_inx_i = 1'b0, unf_zero_i = 1'b0;
    logic [63:0] res_o;
    logic        inx_o, ovf_o, unf_o, trap_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [63:0] res;
        logic        inx, ovf, unf, trap;
        string       tag;
    } want_t;
    want_t pend[$];

    always #2 clk = ~clk;

    rp_round_pack u0 (
        .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .exp_i(exp_i), .frac_i(frac_i),
        .dbl_i(dbl_i), .rmode_i(rmode_i), .dyn_i(dyn_i), .ctl_rmode_i(ctl_rmode_i),
        .q_sw_i(q_sw_i), .q_unf_en_i(q_unf_en_i), .q_inx_en_i(q_inx_en_i),
        .dis_ovf_i(dis_ovf_i), .dis_unf_i(dis_unf_i), .dis_inx_i(dis_inx_i),
        .unf_zero_i(unf_zero_i), .res_o(res_o), .inx_o(inx_o), .ovf_o(ovf_o),
        .unf_o(unf_o), .trap_o(trap_o)
    );

    function automatic want_t model(input logic s, input int e_in, input logic [63:0] f,
                                    input logic dbl, input int md, input logic [6:0] ql,
                                    input string tag);
        want_t w;
        int nb = dbl ? 11 : 40;
        int e = e_in;
        logic [64:0] unit = 65'd1 << nb;
        logic [63:0] low = f & (unit[63:0] - 64'd1);
        logic [63:0] half = unit[63:0] >> 1;
        logic [64:0] q;
        logic bump = (md == 2) || (md == 3 && !s) || (md == 1 && s);
        logic up = (md == 2) ? (low >= half) : (bump && low != 0);
        int emax = dbl ? 2046 : 1150;
        int emin = dbl ? 0 : 896;
        logic qs = ql[6], qu = ql[5], qi = ql[4], dov = ql[3], dun = ql[2], din = ql[1], uz = ql[0];
        w.tag = tag;
        w.ovf = 0; w.unf = 0; w.inx = 0;
        q = {1'b0, f - low} + (up ? unit : 65'd0);
        if (q[64]) begin
            q = 65'd1 << 63;
            e = e + 1;
        end
        if (md == 2 && low == half) q[nb] = 1'b0;
        if (f == 0) begin
            w.res = {s, 63'd0};
        end else if (e > emax) begin
            w.ovf = 1; w.inx = 1;
            w.res = bump ? {s, 11'h7FF, 52'd0} : {s, 11'h7FE, {52{1'b1}}};
        end else if (e <= emin) begin
            w.unf = 1; w.inx = 1;
            w.res = 64'd0;
        end else begin
            w.inx = (low != 0);
            w.res = {s, e[10:0], q[62:11]};
        end
        w.trap = (w.ovf && !(qs && dov)) || (w.unf && qu && !(qs && dun && uz)) ||
                 (w.inx && qi && !(qs && din));
        return w;
    endfunction

    task automatic compare();
        want_t w;
        if (pend.size() == 0) return;
        w = pend.pop_front();
        checks++;
        if (res_o !== w.res || inx_o !== w.inx || ovf_o !== w.ovf ||
            unf_o !== w.unf || trap_o !== w.trap) begin
            fails++;
            $display("FAIL %s actual res=%h i/o/u/t=%b%b%b%b expected res=%h i/o/u/t=%b%b%b%b",
                     w.tag, res_o, inx_o, ovf_o, unf_o, trap_o,
                     w.res, w.inx, w.ovf, w.unf, w.trap);
        end
    endtask

    task automatic put(input logic s, input int e, input logic [63:0] f, input logic dbl,
                       input int rm, input logic dyn, input int crm, input logic [6:0] ql,
                       input string tag);
        @(negedge clk);
        compare();
        sign_i = s; exp_i = e[12:0]; frac_i = f; dbl_i = dbl;
        rmode_i = rm[1:0]; dyn_i = dyn; ctl_rmode_i = crm[1:0];
        {q_sw_i, q_unf_en_i, q_inx_en_i, dis_ovf_i, dis_unf_i, dis_inx_i, unf_zero_i} = ql;
        pend.push_back(model(s, e, f, dbl, dyn ? crm : rm, ql, tag));
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [63:0] st = 64'h9E37_79B9_7F4A_7C15;
        // R10: reset clears outputs
        repeat (3) @(negedge clk);
        checks++;
        if (res_o !== 64'd0 || {inx_o, ovf_o, unf_o, trap_o} !== 4'b0) begin
            fails++;
            $display("FAIL R10 actual res=%h flags=%b%b%b%b expected 0", res_o, inx_o, ovf_o, unf_o, trap_o);
        end
        rst_n = 1'b1;

        // R1: zero fraction
        put(1'b1, 1500, 64'd0, 1'b1, 2, 0, 0, 7'b0111111, "R1");
        put(1'b0, -20, 64'd0, 1'b0, 3, 0, 0, 7'b1111111, "R1");

        // R2 / R8: mode x pattern x precision x sign grid
        for (int p = 0; p < 2; p++)
            for (int m = 0; m < 4; m++)
                for (int pat = 0; pat < 4; pat++)
                    for (int s = 0; s < 2; s++) begin
                        int nb = p ? 11 : 40;
                        logic [63:0] half = 64'd1 << (nb - 1);
                        logic [63:0] base = 64'hC3A5_0000_0000_0000 | (s ? (64'd1 << nb) : 64'd0);
                        logic [63:0] low = (pat == 0) ? 64'd0 : (pat == 1) ? half - 1 :
                                           (pat == 2) ? half : half + 1;
                        put(s[0], p ? 1023 : 1000, base | low, p[0], m, 0, 0, 7'b0, "R2");
                    end

        // R8: tie with even LSB stays, odd LSB rounds up
        put(1'b0, 1100, 64'h8000_0000_0000_0400, 1'b1, 2, 0, 0, 7'b0, "R8");
        put(1'b0, 1100, 64'h8000_0000_0000_0C00, 1'b1, 2, 0, 0, 7'b0, "R8");
        put(1'b1, 950,  64'h8000_0180_0000_0000, 1'b0, 2, 0, 0, 7'b0, "R8");

        // R4: carry out of bit 63
        put(1'b0, 1000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 0, 0, 7'b0, "R4");
        put(1'b1, 1000, 64'hFFFF_FF80_0000_0000, 1'b0, 1, 0, 0, 7'b0, "R4");

        // R3: dynamic mode overrides the instruction field
        put(1'b0, 1023, 64'h8000_0000_0000_0001, 1'b1, 0, 1, 3, 7'b0, "R3");
        put(1'b0, 1023, 64'h8000_0000_0000_0001, 1'b1, 3, 1, 0, 7'b0, "R3");

        // R5: inexact in chop mode
        put(1'b0, 1023, 64'h8000_0000_0000_0001, 1'b1, 0, 0, 0, 7'b0, "R5");
        put(1'b0, 1000, 64'h8000_0080_0000_0000, 1'b0, 0, 0, 0, 7'b0, "R5");

        // R6: overflow edges
        put(1'b0, 2047, 64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b0, "R6");
        put(1'b0, 2047, 64'h8000_0000_0000_0000, 1'b1, 2, 0, 0, 7'b0, "R6");
        put(1'b1, 2047, 64'h8000_0000_0000_0000, 1'b1, 3, 0, 0, 7'b0, "R6");
        put(1'b0, 2046, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2, 0, 0, 7'b0, "R6");
        put(1'b0, 2046, 64'hFFFF_FFFF_FFFF_F000, 1'b1, 0, 0, 0, 7'b0, "R6");
        put(1'b1, 1151, 64'h8000_0000_0000_0000, 1'b0, 1, 0, 0, 7'b0, "R6");
        put(1'b1, 1150, 64'h8000_0000_0000_0000, 1'b0, 1, 0, 0, 7'b0, "R6");

        // R7: underflow edges
        put(1'b1, 0,   64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b0, "R7");
        put(1'b0, 1,   64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b0, "R7");
        put(1'b0, -7,  64'h9000_0000_0000_0000, 1'b1, 2, 0, 0, 7'b0, "R7");
        put(1'b0, 896, 64'h8000_0000_0000_0000, 1'b0, 0, 0, 0, 7'b0, "R7");
        put(1'b0, 897, 64'h8000_0000_0000_0000, 1'b0, 0, 0, 0, 7'b0, "R7");

        // R9: trap gating, qualifier order {sw,unf_en,inx_en,dis_ovf,dis_unf,dis_inx,unf_zero}
        put(1'b0, 2047, 64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b1001000, "R9");
        put(1'b0, 2047, 64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b0001000, "R9");
        put(1'b0, 0,    64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b1100101, "R9");
        put(1'b0, 0,    64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b1100100, "R9");
        put(1'b0, 0,    64'h8000_0000_0000_0000, 1'b1, 0, 0, 0, 7'b0000000, "R9");
        put(1'b0, 1023, 64'h8000_0000_0000_0001, 1'b1, 0, 0, 0, 7'b1010010, "R9");
        put(1'b0, 1023, 64'h8000_0000_0000_0001, 1'b1, 0, 0, 0, 7'b1010000, "R9");

        // R2 / R8 / R9: pseudo-random sweep
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] f;
            logic dbl;
            int e;
            st = st ^ (st << 13); st = st ^ (st >> 7); st = st ^ (st << 17);
            dbl = st[0];
            e = dbl ? int'(st[20:9] % 12'd2200) - 60 : 850 + int'(st[20:9] % 12'd350);
            f = (st[8:6] == 3'd0) ? 64'd0 : (st | 64'h8000_0000_0000_0000);
            if (st[5:4] == 2'd0) f = f & ~64'hFF_FFFF_FFFF;
            put(st[63], e, f, dbl, int'(st[62:61]), st[60], int'(st[59:58]), st[57:51], "R8");
        end

        @(negedge clk);
        compare();
        report();
    end
endmodule